// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block is a small fully associative translation buffer that sits between a core's address generation and its memory pipeline. Each entry describes one pair of adjacent virtual pages and holds two physical frames, an even frame and an odd frame, each with its own valid, dirty and cache-attribute bits. An entry carries a size code that widens both pages together, an address-space ID, and a global flag that lets it match any address space. A request presents a virtual address, an address-space ID, an access kind and a misalignment flag. One clock later the block returns either a physical address with its cache attribute or a fault code, together with the fields a miss or protection handler needs to build its report.

Software maintains the table through an indexed write port. The table can be searched without translating by issuing a probe, which returns the index of the matching entry. It can be emptied with a flush. A two-state controller sequences the flush. In `ST_RUN` requests and writes are served. A `flush_req` in `ST_RUN` takes the transition to `ST_SWEEP`. In `ST_SWEEP` one entry is cleared per cycle, with `busy` high. After the last entry is cleared the controller takes the transition back to `ST_RUN`. Requests and writes presented during `ST_SWEEP` are dropped.

Top module: `tlb_pair_xlate`

## Requirements
- R1: After reset `busy` and `rsp_valid` are 0 and the table is empty, so any translating request gets a refill fault.
- R2: An entry matches when at least one of its halves is valid and the request's VA[31:13] equals the entry's page-pair tag in every bit at or above bit 2k. Here k is the entry's size code, with codes above 4 treated as 4. The entry must also be global, or its ASID must equal the request ASID. An entry is global only when bit 0 of both halves is set.
- R3: When several entries match, the lowest index is used.
- R4: The half is chosen by VA bit (12+2k): 0 selects the even word and 1 selects the odd word. Within a word, the frame number sits in bits 25:6, the attribute in bits 5:3, dirty in bit 2 and valid in bit 1. The physical address is ((frame >> 2k) << (12+2k)) OR (VA AND (2^(12+2k) − 1)).
- R5: Fault codes are 0 none, 1 refill, 2 invalid, 3 modified and 4 address error. With no match the fault is 1 and `rsp_index` is all ones.
- R6: A match whose chosen half is not valid gives fault 2.
- R7: Fault 3 is raised only for a store (kind 2) to a valid half with dirty clear. A fetch (kind 0) or load (kind 1) to such a half translates normally.
- R8: A misaligned translating request gives fault 4 without any lookup. In that case `rsp_pa` is 0, `rsp_index` is all ones and `rsp_bad_va` is the VA.
- R9: On faults 1 to 3 the report carries the request ASID, VA[31:13] as the page-pair number, and a context field equal to it. The 2-bit extension is VA[12:11] when `tiny_pages` is 1 and 0 otherwise. On any fault `rsp_bad_va` is the VA. All report fields are 0 when there is no fault.
- R10: A probe (kind 3) returns the matching index, or all ones when nothing matches, with fault 0, PA 0 and attribute 0. The misalignment flag has no effect on a probe.
- R11: A write whose index is at or beyond the entry count changes no entry.
- R12: A flush sets `busy` for exactly NUM_ENTRIES cycles. Requests during that time produce no response, and afterwards every entry is empty.
- R13: A response appears exactly one cycle after its request. A request in the same cycle as a write sees the table as it was before that write.
- R14: `rsp_attr` is the chosen half's attribute field on a successful translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 probe |
| req_va | input | 32 | Virtual address |
| req_asid | input | 8 | Address-space ID of the request |
| req_misalign | input | 1 | Access is misaligned |
| tiny_pages | input | 1 | Keep the low page-number bits in the report extension |
| wr_en | input | 1 | Write an entry |
| wr_idx | input | IDX_W+1 | Entry index to write |
| wr_vpn2 | input | 19 | Page-pair tag |
| wr_asid | input | 8 | Entry ASID |
| wr_size | input | 3 | Size code k |
| wr_lo0 | input | 26 | Even half word |
| wr_lo1 | input | 26 | Odd half word |
| flush_req | input | 1 | Start clearing every entry |
| busy | output | 1 | Flush sweep in progress |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 3 | Fault code |
| rsp_pa | output | 32 | Physical address |
| rsp_attr | output | 3 | Cache attribute |
| rsp_index | output | IDX_W+1 | Matching index, all ones for none |
| rsp_bad_va | output | 32 | Faulting virtual address |
| rsp_asid | output | 8 | Reported ASID |
| rsp_vpn2 | output | 19 | Reported page-pair number |
| rsp_vpn2_ext | output | 2 | Reported low page-number bits |
| rsp_context | output | 19 | Context field (page-pair number) |

## Verification
The assertions assume that every request input is stable and known whenever `req_valid` is high, and that nothing is driven during reset. They also assume that a fault response follows a request from exactly one cycle earlier. The bench changes inputs only on the falling clock edge, holds each request for one cycle, and keeps all strobes low while reset is active. It loads overlapping entries only in the scenario that exercises match priority. It raises `flush_req` only while `busy` is low, so the start of each sweep is observable.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W    = 32;
    localparam int PFN_W   = 20;
    localparam int ASID_W  = 8;
    localparam int VPN2_W  = 19;
    localparam int SZ_W    = 3;
    localparam int LO_W    = PFN_W + 6;
    localparam int PAGE_SH = 12;
    localparam int MAX_SZ  = 4;

    localparam int LO_G = 0;
    localparam int LO_V = 1;
    localparam int LO_D = 2;
    localparam int LO_C = 3;
    localparam int LO_F = 6;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2,
        KIND_PROBE = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_REFILL   = 3'd1,
        FLT_INVALID  = 3'd2,
        FLT_MODIFIED = 3'd3,
        FLT_ADDR     = 3'd4
    } fault_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_SWEEP = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic [SZ_W-1:0]   sz;
        logic [LO_W-1:0]   lo0;
        logic [LO_W-1:0]   lo1;
    } tlb_entry_t;

    // size code limited to the largest supported page pair
    function automatic logic [2:0] size_step(input logic [SZ_W-1:0] sz);
        return (sz > SZ_W'(MAX_SZ)) ? 3'(MAX_SZ) : 3'(sz);
    endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t       wr_entry,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output tlb_entry_t       ent [NUM_ENTRIES]
);
    tlb_entry_t store [NUM_ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) store[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (clr_en && clr_idx == IDX_W'(i))
                    store[i] <= '0;
                else if (wr_en && wr_idx == IDX_W'(i))
                    store[i] <= wr_entry;
            end
        end
    end

    assign ent = store;
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic [VPN2_W-1:0]      tag_vpn2 [NUM_ENTRIES],
    input  logic [ASID_W-1:0]      tag_asid [NUM_ENTRIES],
    input  logic [SZ_W-1:0]        tag_sz   [NUM_ENTRIES],
    input  logic [NUM_ENTRIES-1:0] tag_live,
    input  logic [NUM_ENTRIES-1:0] tag_glob,
    input  logic [VPN2_W-1:0]      vpn2,
    input  logic [ASID_W-1:0]      asid,
    output logic                   hit,
    output logic [IDX_W-1:0]       hit_idx
);
    logic [NUM_ENTRIES-1:0] mvec;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        logic [2:0]        step;
        logic [VPN2_W-1:0] care;
        logic              same_pg;
        logic              same_as;
        always_comb begin
            step    = size_step(tag_sz[i]);
            care    = {VPN2_W{1'b1}} << (2 * step);
            same_pg = ((vpn2 ^ tag_vpn2[i]) & care) == '0;
            same_as = (tag_asid[i] == asid);
        end
        assign mvec[i] = tag_live[i] & same_pg & (tag_glob[i] | same_as);
    end

    // lowest matching index wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (mvec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
(
    input  logic              hit,
    input  logic [SZ_W-1:0]   sz,
    input  logic [LO_W-1:0]   lo0,
    input  logic [LO_W-1:0]   lo1,
    input  logic [VA_W-1:0]   va,
    input  req_kind_e         kind,
    input  logic              misalign,
    input  logic              tiny,
    input  logic [ASID_W-1:0] asid,
    output fault_e            fault,
    output logic [VA_W-1:0]   pa,
    output logic [2:0]        attr,
    output logic [ASID_W-1:0] rpt_asid,
    output logic [VPN2_W-1:0] rpt_vpn2,
    output logic [1:0]        rpt_ext,
    output logic [VA_W-1:0]   bad_va
);
    logic [2:0]      step;
    logic [4:0]      shamt;
    logic [LO_W-1:0] half;
    logic [VA_W-1:0] base;
    logic [VA_W-1:0] offs;
    logic            tlb_flt;
    logic            unused_half_g;

    always_comb begin
        step  = size_step(sz);
        shamt = 5'(PAGE_SH + 2 * step);
        half  = va[shamt] ? lo1 : lo0;
        base  = (VA_W'(half[LO_W-1:LO_F]) >> (2 * step)) << shamt;
        offs  = va & ((VA_W'(1) << shamt) - VA_W'(1));
    end

    assign unused_half_g = half[LO_G];

    always_comb begin
        if (kind == KIND_PROBE)                      fault = FLT_NONE;
        else if (misalign)                           fault = FLT_ADDR;
        else if (!hit)                               fault = FLT_REFILL;
        else if (!half[LO_V])                        fault = FLT_INVALID;
        else if (kind == KIND_STORE && !half[LO_D])  fault = FLT_MODIFIED;
        else                                         fault = FLT_NONE;
    end

    always_comb begin
        tlb_flt  = (fault == FLT_REFILL) || (fault == FLT_INVALID) || (fault == FLT_MODIFIED);
        pa       = (fault == FLT_NONE && kind != KIND_PROBE) ? (base | offs) : '0;
        attr     = (fault == FLT_NONE && kind != KIND_PROBE) ? half[LO_C+2:LO_C] : '0;
        rpt_asid = tlb_flt ? asid : '0;
        rpt_vpn2 = tlb_flt ? va[VA_W-1:PAGE_SH+1] : '0;
        rpt_ext  = (tlb_flt && tiny) ? va[PAGE_SH:PAGE_SH-1] : 2'b00;
        bad_va   = (fault != FLT_NONE) ? va : '0;
    end
endmodule

// File: rtl/tlb_pair_xlate.sv
module tlb_pair_xlate
    import tlb_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [31:0]       req_va,
    input  logic [7:0]        req_asid,
    input  logic              req_misalign,
    input  logic              tiny_pages,
    input  logic              wr_en,
    input  logic [IDX_W:0]    wr_idx,
    input  logic [18:0]       wr_vpn2,
    input  logic [7:0]        wr_asid,
    input  logic [2:0]        wr_size,
    input  logic [25:0]       wr_lo0,
    input  logic [25:0]       wr_lo1,
    input  logic              flush_req,
    output logic              busy,
    output logic              rsp_valid,
    output logic [2:0]        rsp_fault,
    output logic [31:0]       rsp_pa,
    output logic [2:0]        rsp_attr,
    output logic [IDX_W:0]    rsp_index,
    output logic [31:0]       rsp_bad_va,
    output logic [7:0]        rsp_asid,
    output logic [18:0]       rsp_vpn2,
    output logic [1:0]        rsp_vpn2_ext,
    output logic [18:0]       rsp_context
);
    ctl_state_e       state, state_nxt;
    logic [IDX_W-1:0] sweep_ptr;
    logic             wr_ok;
    tlb_entry_t       wr_entry;
    tlb_entry_t       ent [NUM_ENTRIES];

    logic [VPN2_W-1:0]      tag_vpn2 [NUM_ENTRIES];
    logic [ASID_W-1:0]      tag_asid [NUM_ENTRIES];
    logic [SZ_W-1:0]        tag_sz   [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] tag_live;
    logic [NUM_ENTRIES-1:0] tag_glob;

    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    req_kind_e         kind;
    fault_e            fault;
    logic [VA_W-1:0]   pa, bad_va;
    logic [2:0]        attr;
    logic [ASID_W-1:0] rpt_asid;
    logic [VPN2_W-1:0] rpt_vpn2;
    logic [1:0]        rpt_ext;
    logic [IDX_W:0]    idx_out;

    assign busy  = (state == ST_SWEEP);
    assign kind  = req_kind_e'(req_kind);
    assign wr_ok = wr_en && (state == ST_RUN) && (wr_idx < (IDX_W+1)'(NUM_ENTRIES));
    assign wr_entry = '{vpn2: wr_vpn2, asid: wr_asid, sz: wr_size, lo0: wr_lo0, lo1: wr_lo1};

    // controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            sweep_ptr <= '0;
        end else begin
            state     <= state_nxt;
            sweep_ptr <= (state == ST_SWEEP) ? sweep_ptr + IDX_W'(1) : '0;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:   if (flush_req) state_nxt = ST_SWEEP;
            ST_SWEEP: if (sweep_ptr == IDX_W'(NUM_ENTRIES - 1)) state_nxt = ST_RUN;
            default:  state_nxt = ST_RUN;
        endcase
    end

    tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .wr_idx   (wr_idx[IDX_W-1:0]),
        .wr_entry (wr_entry),
        .clr_en   (busy),
        .clr_idx  (sweep_ptr),
        .ent      (ent)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_tag
        assign tag_vpn2[g] = ent[g].vpn2;
        assign tag_asid[g] = ent[g].asid;
        assign tag_sz[g]   = ent[g].sz;
        assign tag_live[g] = ent[g].lo0[LO_V] | ent[g].lo1[LO_V];
        assign tag_glob[g] = ent[g].lo0[LO_G] & ent[g].lo1[LO_G];
    end

    tlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .tag_vpn2 (tag_vpn2),
        .tag_asid (tag_asid),
        .tag_sz   (tag_sz),
        .tag_live (tag_live),
        .tag_glob (tag_glob),
        .vpn2     (req_va[VA_W-1:PAGE_SH+1]),
        .asid     (req_asid),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    tlb_xlate u_xlate (
        .hit      (hit),
        .sz       (ent[hit_idx].sz),
        .lo0      (ent[hit_idx].lo0),
        .lo1      (ent[hit_idx].lo1),
        .va       (req_va),
        .kind     (kind),
        .misalign (req_misalign),
        .tiny     (tiny_pages),
        .asid     (req_asid),
        .fault    (fault),
        .pa       (pa),
        .attr     (attr),
        .rpt_asid (rpt_asid),
        .rpt_vpn2 (rpt_vpn2),
        .rpt_ext  (rpt_ext),
        .bad_va   (bad_va)
    );

    always_comb begin
        if (req_misalign && kind != KIND_PROBE) idx_out = '1;
        else if (hit)                           idx_out = {1'b0, hit_idx};
        else                                    idx_out = '1;
    end

    // controller: registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_fault    <= '0;
            rsp_pa       <= '0;
            rsp_attr     <= '0;
            rsp_index    <= '0;
            rsp_bad_va   <= '0;
            rsp_asid     <= '0;
            rsp_vpn2     <= '0;
            rsp_vpn2_ext <= '0;
            rsp_context  <= '0;
        end else if (req_valid && state == ST_RUN) begin
            rsp_valid    <= 1'b1;
            rsp_fault    <= fault;
            rsp_pa       <= pa;
            rsp_attr     <= attr;
            rsp_index    <= idx_out;
            rsp_bad_va   <= bad_va;
            rsp_asid     <= rpt_asid;
            rsp_vpn2     <= rpt_vpn2;
            rsp_vpn2_ext <= rpt_ext;
            rsp_context  <= rpt_vpn2;
        end else begin
            rsp_valid    <= 1'b0;
            rsp_fault    <= '0;
            rsp_pa       <= '0;
            rsp_attr     <= '0;
            rsp_index    <= '0;
            rsp_bad_va   <= '0;
            rsp_asid     <= '0;
            rsp_vpn2     <= '0;
            rsp_vpn2_ext <= '0;
            rsp_context  <= '0;
        end
    end
endmodule

// File: rtl/tlb_pair_xlate_chk.sv
module tlb_pair_xlate_chk #(
    parameter int IDX_W = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic [1:0]     req_kind,
    input logic [31:0]    req_va,
    input logic           flush_req,
    input logic           busy,
    input logic           rsp_valid,
    input logic [2:0]     rsp_fault,
    input logic [31:0]    rsp_pa,
    input logic [IDX_W:0] rsp_index,
    input logic [31:0]    rsp_bad_va,
    input logic [18:0]    rsp_vpn2,
    input logic [18:0]    rsp_context
);
    assert_refill_nomatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 3'd1) |-> (rsp_index == '1));

    assert_modified_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 3'd3) |-> ($past(req_kind) == 2'd2));

    assert_addr_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 3'd4) |-> (rsp_pa == '0 && rsp_bad_va == $past(req_va)));

    assert_context_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault >= 3'd1 && rsp_fault <= 3'd3) |-> (rsp_context == rsp_vpn2));

    assert_flush_enter_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !busy) |=> busy);

    assert_flush_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rsp_valid);

    assert_rsp_origin_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    assert_rsp_served_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> rsp_valid);

    assert_idle_clean_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_fault == 3'd0));
endmodule

bind tlb_pair_xlate tlb_pair_xlate_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_va      (req_va),
    .flush_req   (flush_req),
    .busy        (busy),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_pa      (rsp_pa),
    .rsp_index   (rsp_index),
    .rsp_bad_va  (rsp_bad_va),
    .rsp_vpn2    (rsp_vpn2),
    .rsp_context (rsp_context)
);

// File: tb/tlb_pair_xlate_bench.sv
module tlb_pair_xlate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_misalign = 0, tiny_pages = 0;
    logic [1:0] req_kind = 0;
    logic [31:0] req_va = 0;
    logic [7:0] req_asid = 0;
    logic wr_en = 0;
    logic [IW:0] wr_idx = 0;
    logic [18:0] wr_vpn2 = 0;
    logic [7:0] wr_asid = 0;
    logic [2:0] wr_size = 0;
    logic [25:0] wr_lo0 = 0, wr_lo1 = 0;
    logic flush_req = 0;
    logic busy, rsp_valid;
    logic [2:0] rsp_fault, rsp_attr;
    logic [31:0] rsp_pa, rsp_bad_va;
    logic [IW:0] rsp_index;
    logic [7:0] rsp_asid;
    logic [18:0] rsp_vpn2, rsp_context;
    logic [1:0] rsp_vpn2_ext;

    int total = 0;
    int bad = 0;

    logic [18:0] m_vpn2 [N];
    logic [7:0]  m_asid [N];
    logic [2:0]  m_sz   [N];
    logic [25:0] m_lo0  [N];
    logic [25:0] m_lo1  [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_pair_xlate #(.NUM_ENTRIES(N)) u_tlb_pair_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_va(req_va), .req_asid(req_asid), .req_misalign(req_misalign),
        .tiny_pages(tiny_pages), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2),
        .wr_asid(wr_asid), .wr_size(wr_size), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
        .flush_req(flush_req), .busy(busy), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_pa(rsp_pa), .rsp_attr(rsp_attr), .rsp_index(rsp_index),
        .rsp_bad_va(rsp_bad_va), .rsp_asid(rsp_asid), .rsp_vpn2(rsp_vpn2),
        .rsp_vpn2_ext(rsp_vpn2_ext), .rsp_context(rsp_context)
    );

    function automatic logic [25:0] mk_lo(input logic [19:0] pfn, input logic [2:0] c,
                                          input logic d, input logic v, input logic g);
        return {pfn, c, d, v, g};
    endfunction

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_vpn2[i] = 0; m_asid[i] = 0; m_sz[i] = 0; m_lo0[i] = 0; m_lo1[i] = 0;
        end
    endtask

    // reference lookup built from the requirements
    task automatic model(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind,
                         input logic mis, output logic [2:0] f, output logic [31:0] pa,
                         output logic [IW:0] idx, output logic [2:0] attr);
        int hit_i = -1;
        int k;
        logic [25:0] half;
        f = 0; pa = 0; attr = 0;
        for (int i = 0; i < N; i++) begin
            int kk = (m_sz[i] > 4) ? 4 : int'(m_sz[i]);
            bit live = m_lo0[i][1] | m_lo1[i][1];
            bit glob = m_lo0[i][0] & m_lo1[i][0];
            bit pg = ((va[31:13] >> (2*kk)) == (m_vpn2[i] >> (2*kk)));
            if (hit_i < 0 && live && pg && (glob || m_asid[i] == asid)) hit_i = i;
        end
        if (mis && kind != 2'd3) idx = '1;
        else idx = (hit_i < 0) ? '1 : (IW+1)'(hit_i);
        if (kind == 2'd3) f = 0;
        else if (mis) f = 4;
        else if (hit_i < 0) f = 1;
        else begin
            k = (m_sz[hit_i] > 4) ? 4 : int'(m_sz[hit_i]);
            half = va[12 + 2*k] ? m_lo1[hit_i] : m_lo0[hit_i];
            if (!half[1]) f = 2;
            else if (kind == 2'd2 && !half[2]) f = 3;
            else begin
                f = 0;
                pa = ((32'(half[25:6]) >> (2*k)) << (12 + 2*k)) | (va & ((32'd1 << (12 + 2*k)) - 1));
                attr = half[5:3];
            end
        end
    endtask

    task automatic write_entry(input int idx, input logic [18:0] v2, input logic [7:0] as,
                               input logic [2:0] sz, input logic [25:0] l0, input logic [25:0] l1);
        @(negedge clk);
        wr_en = 1; wr_idx = (IW+1)'(idx); wr_vpn2 = v2; wr_asid = as; wr_size = sz;
        wr_lo0 = l0; wr_lo1 = l1;
        @(negedge clk);
        wr_en = 0;
        if (idx < N) begin
            m_vpn2[idx] = v2; m_asid[idx] = as; m_sz[idx] = sz; m_lo0[idx] = l0; m_lo1[idx] = l1;
        end
    endtask

    task automatic issue(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind,
                         input logic mis, input logic tiny);
        @(negedge clk);
        req_valid = 1; req_va = va; req_asid = asid; req_kind = kind;
        req_misalign = mis; tiny_pages = tiny;
        @(negedge clk);
        req_valid = 0; req_misalign = 0; tiny_pages = 0;
    endtask

    task automatic req_check(input string rq, input logic [31:0] va, input logic [7:0] asid,
                             input logic [1:0] kind, input logic mis, input logic tiny);
        logic [2:0] f, at;
        logic [31:0] pa;
        logic [IW:0] idx;
        bit tf;
        model(va, asid, kind, mis, f, pa, idx, at);
        tf = (f >= 1 && f <= 3);
        issue(va, asid, kind, mis, tiny);
        check(rq, "valid", 32'(rsp_valid), 1);
        check(rq, "fault", 32'(rsp_fault), 32'(f));
        check(rq, "pa", rsp_pa, pa);
        check(rq, "index", 32'(rsp_index), 32'(idx));
        check("R14", "attr", 32'(rsp_attr), 32'(at));
        check("R9", "bad_va", rsp_bad_va, (f != 0) ? va : 32'd0);
        check("R9", "asid", 32'(rsp_asid), tf ? 32'(asid) : 0);
        check("R9", "vpn2", 32'(rsp_vpn2), tf ? 32'(va[31:13]) : 0);
        check("R9", "context", 32'(rsp_context), tf ? 32'(va[31:13]) : 0);
        check("R9", "ext", 32'(rsp_vpn2_ext), (tf && tiny) ? 32'(va[12:11]) : 0);
    endtask

    task automatic t_reset();
        check("R1", "busy", 32'(busy), 0);
        check("R1", "rsp_valid", 32'(rsp_valid), 0);
        req_check("R1", 32'h0002_0ABC, 8'd5, 2'd1, 0, 0);
        check("R1", "refill", 32'(rsp_fault), 1);
    endtask

    task automatic t_even_odd();
        write_entry(0, 19'h10, 8'd5, 3'd0, mk_lo(20'h00123, 3'd2, 1, 1, 0), mk_lo(20'h00456, 3'd3, 0, 1, 0));
        req_check("R4", 32'h0002_0ABC, 8'd5, 2'd1, 0, 0);
        check("R4", "even pa", rsp_pa, 32'h0012_3ABC);
        req_check("R4", 32'h0002_1ABC, 8'd5, 2'd0, 0, 0);
        check("R4", "odd pa", rsp_pa, 32'h0045_6ABC);
        check("R14", "odd attr", 32'(rsp_attr), 3);
    endtask

    task automatic t_large_page();
        write_entry(1, 19'h800, 8'd5, 3'd2, mk_lo(20'h00340, 3'd3, 1, 1, 0), mk_lo(20'h00570, 3'd5, 1, 1, 0));
        req_check("R2", 32'h0100_5678, 8'd5, 2'd1, 0, 0);
        check("R4", "large even pa", rsp_pa, 32'h0034_5678);
        req_check("R2", 32'h0101_2345, 8'd5, 2'd2, 0, 0);
        check("R4", "large odd pa", rsp_pa, 32'h0057_2345);
        req_check("R2", 32'h0102_0000, 8'd5, 2'd1, 0, 0);
        check("R2", "outside large", 32'(rsp_fault), 1);
    endtask

    task automatic t_global_asid();
        write_entry(2, 19'h200, 8'h77, 3'd0, mk_lo(20'h00aaa, 3'd1, 1, 1, 1), mk_lo(20'h00bbb, 3'd1, 1, 1, 1));
        write_entry(7, 19'h300, 8'h77, 3'd0, mk_lo(20'h00ccc, 3'd1, 1, 1, 0), mk_lo(20'h00ddd, 3'd1, 1, 1, 0));
        write_entry(8, 19'h380, 8'h10, 3'd0, mk_lo(20'h00eee, 3'd1, 1, 1, 1), mk_lo(20'h00fff, 3'd1, 1, 1, 0));
        req_check("R2", 32'h0040_0010, 8'h01, 2'd1, 0, 0);
        check("R2", "global hit", 32'(rsp_fault), 0);
        req_check("R2", 32'h0060_0010, 8'h01, 2'd1, 0, 0);
        check("R2", "asid mismatch", 32'(rsp_fault), 1);
        req_check("R2", 32'h0060_0010, 8'h77, 2'd1, 0, 0);
        req_check("R2", 32'h0070_0010, 8'h11, 2'd1, 0, 0);
        check("R2", "half global", 32'(rsp_fault), 1);
    endtask

    task automatic t_faults();
        write_entry(4, 19'h600, 8'd5, 3'd0, mk_lo(20'h00111, 3'd0, 1, 1, 0), mk_lo(20'h00222, 3'd0, 1, 0, 0));
        req_check("R6", 32'h00C0_1000, 8'd5, 2'd1, 0, 0);
        check("R6", "invalid", 32'(rsp_fault), 2);
        req_check("R7", 32'h0002_1ABC, 8'd5, 2'd2, 0, 0);
        check("R7", "modified", 32'(rsp_fault), 3);
        req_check("R7", 32'h0002_1ABC, 8'd5, 2'd0, 0, 0);
        check("R7", "fetch clean ok", 32'(rsp_fault), 0);
        req_check("R7", 32'h0002_0ABC, 8'd5, 2'd2, 0, 0);
        check("R7", "store dirty ok", 32'(rsp_fault), 0);
        req_check("R8", 32'h0002_0ABD, 8'd5, 2'd1, 1, 0);
        check("R8", "addr err", 32'(rsp_fault), 4);
        req_check("R9", 32'h0140_1800, 8'd9, 2'd1, 0, 1);
        check("R9", "ext tiny", 32'(rsp_vpn2_ext), 3);
        req_check("R5", 32'h0140_1800, 8'd9, 2'd1, 0, 0);
        check("R5", "index none", 32'(rsp_index), 32'h1f);
    endtask

    task automatic t_priority();
        write_entry(9,  19'h700, 8'd3, 3'd0, mk_lo(20'h00901, 3'd0, 1, 1, 0), mk_lo(20'h00902, 3'd0, 1, 1, 0));
        write_entry(11, 19'h700, 8'd3, 3'd0, mk_lo(20'h00b01, 3'd0, 1, 1, 0), mk_lo(20'h00b02, 3'd0, 1, 1, 0));
        req_check("R3", 32'h00E0_0044, 8'd3, 2'd1, 0, 0);
        check("R3", "lowest index", 32'(rsp_index), 9);
        check("R3", "lowest pa", rsp_pa, 32'h0090_1044);
    endtask

    task automatic t_probe();
        req_check("R10", 32'h0002_1000, 8'd5, 2'd3, 0, 0);
        check("R10", "probe idx", 32'(rsp_index), 0);
        req_check("R10", 32'h0002_1001, 8'd5, 2'd3, 1, 0);
        check("R10", "probe misalign", 32'(rsp_fault), 0);
        req_check("R10", 32'h0400_0000, 8'd5, 2'd3, 0, 0);
        check("R10", "probe miss", 32'(rsp_index), 32'h1f);
        req_check("R10", 32'h00C0_1000, 8'd5, 2'd3, 0, 0);
        check("R10", "probe invalid half", 32'(rsp_index), 4);
    endtask

    task automatic t_bad_write();
        write_entry(16, 19'h10, 8'd5, 3'd0, mk_lo(20'h0dead, 3'd0, 1, 1, 0), mk_lo(20'h0beef, 3'd0, 1, 1, 0));
        write_entry(31, 19'hA00, 8'd5, 3'd0, mk_lo(20'h00777, 3'd0, 1, 1, 0), mk_lo(20'h00777, 3'd0, 1, 1, 0));
        req_check("R11", 32'h0002_0ABC, 8'd5, 2'd1, 0, 0);
        check("R11", "entry0 kept", rsp_pa, 32'h0012_3ABC);
        req_check("R11", 32'h0140_0000, 8'd5, 2'd1, 0, 0);
        check("R11", "no new entry", 32'(rsp_fault), 1);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        wr_en = 1; wr_idx = 6; wr_vpn2 = 19'hB00; wr_asid = 8'd5; wr_size = 0;
        wr_lo0 = mk_lo(20'h00606, 3'd0, 1, 1, 0); wr_lo1 = mk_lo(20'h00607, 3'd0, 1, 1, 0);
        req_valid = 1; req_va = 32'h0160_0010; req_asid = 8'd5; req_kind = 2'd1;
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        check("R13", "old table", 32'(rsp_fault), 1);
        m_vpn2[6] = 19'hB00; m_asid[6] = 8'd5; m_sz[6] = 0;
        m_lo0[6] = mk_lo(20'h00606, 3'd0, 1, 1, 0); m_lo1[6] = mk_lo(20'h00607, 3'd0, 1, 1, 0);
        req_check("R13", 32'h0160_0010, 8'd5, 2'd1, 0, 0);
        check("R13", "new entry", rsp_pa, 32'h0060_6010);
    endtask

    task automatic t_flush();
        int cnt = 0;
        @(negedge clk);
        flush_req = 1;
        @(negedge clk);
        flush_req = 0;
        check("R12", "busy start", 32'(busy), 1);
        req_valid = 1; req_va = 32'h0002_0ABC; req_asid = 8'd5; req_kind = 2'd1;
        while (busy && cnt < 100) begin
            @(negedge clk);
            cnt++;
            check("R12", "quiet", 32'(rsp_valid), 0);
        end
        req_valid = 0;
        check("R12", "busy cycles", 32'(cnt), N);
        model_clear();
        req_check("R12", 32'h0002_0ABC, 8'd5, 2'd1, 0, 0);
        check("R12", "cleared", 32'(rsp_fault), 1);
        req_check("R12", 32'h0040_0010, 8'h01, 2'd1, 0, 0);
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_even_odd();
        t_large_page();
        t_global_asid();
        t_faults();
        t_priority();
        t_probe();
        t_bad_write();
        t_same_cycle();
        t_flush();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule